// File: doc/BRIEF.md
# Arbitrated Byte DMA Channel

This block is one DMA channel that moves single bytes between a peripheral and a byte-wide memory port. Software sets up four 32-bit registers: a physical (real) address, a virtual address, a byte count and a control word. A control bit picks the direction. The peripheral asks for service by holding its request line high. The channel moves one byte per grant for as long as the request stays high and the count is not zero. A control write can also start a forced transfer that runs without a request from the peripheral.

The channel may only use the bus when a grant bit that belongs to it is set in a shared 16-bit arbitration register. A parameter mask selects which bits of that register are its grant bits. While a transfer is wanted but the grant is missing, the channel moves no data and shows a busy flag. On the last byte it sets a done flag and, when the `USE_TC` parameter enables it, sends a one-cycle terminal-count pulse to the peripheral. On the memory side it uses a valid/ready handshake and keeps only one byte in flight at a time.

Top module: `byte_dma_channel`

## Requirements
- R1: After synchronous reset, all four registers read zero, and `mem_valid`, `dev_ack` and `dev_tc` are low.
- R2: The control register is at index 3. A write to it keeps only the bits in mask 0xfd000e00 and clears every other bit. Bit 22 (bus error) always reads zero.
- R3: The real address is at index 0, the virtual address at index 1 and the count at index 2. A write to the virtual address clears its two low bits.
- R4: The channel is granted when `arb_ctl & GRANT_MASK` is nonzero. While a transfer is wanted and the grant is missing, control bit 25 (busy) reads one and no memory access is made. Once the grant arrives, bit 25 clears and the transfer goes ahead.
- R5: Control bit 30 = 1 gives a memory-to-device transfer: a byte is read from memory and presented on `dev_wdata` while `dev_ack` is high. Bit 30 = 0 gives device-to-memory: the byte on `dev_rdata` is written to memory.
- R6: A byte moves only while the request (`dev_req` or a forced start) is active and the count is nonzero. After each byte, both addresses go up by one and the count goes down by one.
- R7: When the count reaches zero, control bit 0 sets, `dev_tc` pulses high for exactly one cycle, and no further byte moves.
- R8: A control write with bits 30 and 29 both set starts a forced transfer. The transfer runs with `dev_req` low until the count reaches zero.
- R9: Only one memory access is outstanding. `mem_valid` stays high and `mem_addr` stays stable until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 2 | Register index for the write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 2 | Register index for the read |
| reg_rd_data | output | 32 | Combinational read data |
| arb_ctl | input | 16 | Shared arbitration register (grant bits) |
| dev_req | input | 1 | Peripheral transfer request |
| dev_rdata | input | 8 | Byte from the peripheral (device-to-memory) |
| dev_wdata | output | 8 | Byte to the peripheral (memory-to-device) |
| dev_ack | output | 1 | One-cycle strobe: one byte consumed or delivered |
| dev_tc | output | 1 | One-cycle terminal-count pulse |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts or completes the access |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ready` |

## Verification
Suppose an edge finds the channel idle, with a request active, the count nonzero and the grant present. That edge latches the byte and raises `mem_valid` for the following cycle. The edge that sees `mem_ready` does three things: it updates the addresses and the count, it raises `dev_ack` (and, on the last byte, `dev_tc`) for the next cycle, and it makes `dev_wdata` valid for that same cycle. The earliest next issue is one edge later, so each byte takes at least two cycles. The bench drives inputs and samples outputs on the falling edge. It counts acknowledges and terminal-count pulses on those falling edges, waits for the done bit before it checks any result, and holds a request for several cycles before it concludes that no transfer took place.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int REG_W     = 32;
    localparam int REG_COUNT = 4;
    localparam int IDX_W     = $clog2(REG_COUNT);

    localparam logic [IDX_W-1:0] IDX_REAL  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_VIRT  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_COUNT = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 2'd3;

    localparam logic [REG_W-1:0] CTRL_WR_MASK = 32'hfd00_0e00;
    localparam int BIT_DONE  = 0;
    localparam int BIT_BERR  = 22;
    localparam int BIT_BUSY  = 25;
    localparam int BIT_FRC   = 29;
    localparam int BIT_DIR   = 30;

    typedef enum logic [0:0] {MV_IDLE, MV_XFER} mover_state_e;

    typedef struct packed {
        logic [REG_W-1:0] real_a;
        logic [REG_W-1:0] virt_a;
        logic [REG_W-1:0] count;
        logic [REG_W-1:0] ctrl;
    } chan_regs_t;

    function automatic logic starts_forced(input logic [REG_W-1:0] w);
        return w[BIT_DIR] & w[BIT_FRC];
    endfunction

endpackage

// File: rtl/dma_grant_check.sv
module dma_grant_check #(
    parameter int              ARB_W      = 16,
    parameter logic [ARB_W-1:0] GRANT_MASK = 16'h0004
) (
    input  logic [ARB_W-1:0] arb,
    output logic             granted
);
    assign granted = |(arb & GRANT_MASK);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step,
    input  logic             busy_upd,
    input  logic             busy_val,
    output chan_regs_t       regs,
    output logic             forced
);
    logic last_byte;
    assign last_byte = (regs.count == 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs   <= '0;
            forced <= 1'b0;
        end else begin
            if (busy_upd)
                regs.ctrl[BIT_BUSY] <= busy_val;
            if (step) begin
                regs.real_a <= regs.real_a + 32'd1;
                regs.virt_a <= regs.virt_a + 32'd1;
                regs.count  <= regs.count - 32'd1;
                if (last_byte) begin
                    regs.ctrl[BIT_DONE] <= 1'b1;
                    forced              <= 1'b0;
                end
            end
            if (wr_en) begin
                case (wr_idx)
                    IDX_REAL:  regs.real_a <= wr_data;
                    IDX_VIRT:  regs.virt_a <= {wr_data[REG_W-1:2], 2'b00};
                    IDX_COUNT: regs.count  <= wr_data;
                    default: begin
                        regs.ctrl <= wr_data & CTRL_WR_MASK;
                        forced    <= starts_forced(wr_data);
                    end
                endcase
            end
        end
    end

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en) |=> regs.count == $past(regs.count) - 32'd1);
    assert_step_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        step |-> regs.count != 32'd0);
    assert_virt_align_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_VIRT) |=> regs.virt_a[1:0] == 2'b00);
    assert_berr_zero_R2: assert property (@(posedge clk) disable iff (rst)
        regs.ctrl[BIT_BERR] == 1'b0);

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit USE_TC = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              want,
    input  logic              granted,
    input  logic              dir_m2d,
    input  logic              count_is_one,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              step,
    output logic              busy_upd,
    output logic              busy_val,
    output logic              dev_ack,
    output logic              dev_tc,
    output logic [DATA_W-1:0] dev_wdata
);
    mover_state_e      state;
    logic              dir_q;
    logic [DATA_W-1:0] byte_q;

    assign mem_valid = (state == MV_XFER);
    assign mem_write = mem_valid && !dir_q;
    assign mem_wdata = byte_q;
    assign step      = mem_valid && mem_ready;
    assign busy_upd  = (state == MV_IDLE);
    assign busy_val  = want && !granted;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MV_IDLE;
            dir_q     <= 1'b0;
            byte_q    <= '0;
            dev_ack   <= 1'b0;
            dev_tc    <= 1'b0;
            dev_wdata <= '0;
        end else begin
            dev_ack <= 1'b0;
            dev_tc  <= 1'b0;
            case (state)
                MV_IDLE: begin
                    if (want && granted) begin
                        state  <= MV_XFER;
                        dir_q  <= dir_m2d;
                        byte_q <= dev_rdata;
                    end
                end
                default: begin
                    if (mem_ready) begin
                        state   <= MV_IDLE;
                        dev_ack <= 1'b1;
                        dev_tc  <= USE_TC && count_is_one;
                        if (dir_q)
                            dev_wdata <= mem_rdata;
                    end
                end
            endcase
        end
    end

    assert_grant_before_issue_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(granted));
    assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid);
    assert_tc_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dev_tc |=> !dev_tc);

endmodule

// File: rtl/byte_dma_channel.sv
module byte_dma_channel
    import dma_chan_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter int               ARB_W      = 16,
    parameter logic [ARB_W-1:0] GRANT_MASK = 16'h0004,
    parameter bit               USE_TC     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_idx,
    input  logic [31:0]       reg_wr_data,
    input  logic [1:0]        reg_rd_idx,
    output logic [31:0]       reg_rd_data,
    input  logic [ARB_W-1:0]  arb_ctl,
    input  logic              dev_req,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_ack,
    output logic              dev_tc,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    chan_regs_t regs;
    logic forced, granted, want, step, busy_upd, busy_val;

    dma_grant_check #(.ARB_W(ARB_W), .GRANT_MASK(GRANT_MASK)) u_grant (
        .arb(arb_ctl), .granted(granted)
    );

    dma_regfile u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
        .step(step), .busy_upd(busy_upd), .busy_val(busy_val),
        .regs(regs), .forced(forced)
    );

    assign want = (dev_req || forced) && (regs.count != 32'd0);

    dma_mover #(.DATA_W(DATA_W), .USE_TC(USE_TC)) u_mover (
        .clk(clk), .rst(rst),
        .want(want), .granted(granted), .dir_m2d(regs.ctrl[BIT_DIR]),
        .count_is_one(regs.count == 32'd1),
        .dev_rdata(dev_rdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_wdata(mem_wdata),
        .step(step), .busy_upd(busy_upd), .busy_val(busy_val),
        .dev_ack(dev_ack), .dev_tc(dev_tc), .dev_wdata(dev_wdata)
    );

    assign mem_addr = regs.real_a;

    always_comb begin
        case (reg_rd_idx)
            IDX_REAL:  reg_rd_data = regs.real_a;
            IDX_VIRT:  reg_rd_data = regs.virt_a;
            IDX_COUNT: reg_rd_data = regs.count;
            default:   reg_rd_data = regs.ctrl;
        endcase
    end

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));
    assert_done_no_move_R7: assert property (@(posedge clk) disable iff (rst)
        (regs.count == 32'd0 && !mem_valid) |=> !mem_valid);

endmodule

// File: tb/tb_byte_dma_channel.sv
module tb_byte_dma_channel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic [15:0] arb_ctl = 16'h0004;
    logic        dev_req = 1'b0;
    logic [7:0]  dev_base = 8'h00;
    logic [7:0]  dev_rdata, dev_wdata, mem_wdata, mem_rdata;
    logic        dev_ack, dev_tc, mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr;

    byte_dma_channel dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .arb_ctl(arb_ctl), .dev_req(dev_req), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_tc(dev_tc),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // memory model, preload port, wait-state generator
    logic [7:0] mem [0:63];
    logic       pl_we = 1'b0;
    logic [5:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    logic       wait_mode = 1'b0;
    logic [1:0] rdy_cnt = '0;
    assign mem_ready = !wait_mode || (rdy_cnt == 2'd2);
    assign mem_rdata = mem[mem_addr[5:0]];
    always @(posedge clk) begin
        rdy_cnt <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
        if (pl_we) mem[pl_addr] <= pl_data;
        else if (mem_valid && mem_ready && mem_write) mem[mem_addr[5:0]] <= mem_wdata;
    end

    // peripheral side monitors
    int ack_n = 0;
    int tc_n  = 0;
    int mv_n  = 0;
    int stall_err = 0;
    logic [7:0] cap [0:255];
    assign dev_rdata = dev_base + ack_n[7:0];
    always @(negedge clk) begin
        if (dev_ack) begin
            cap[ack_n[7:0]] <= dev_wdata;
            ack_n <= ack_n + 1;
        end
        if (dev_tc) tc_n <= tc_n + 1;
    end
    logic prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(posedge clk) begin
        if (mem_valid) mv_n <= mv_n + 1;
        if (!rst && prev_stall && (!mem_valid || mem_addr != prev_addr))
            stall_err <= stall_err + 1;
        prev_stall <= !rst && mem_valid && !mem_ready;
        prev_addr  <= mem_addr;
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: run hung, actual=expired expected=finished");
        report();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        reg_rd_idx = idx;
        #1 d = reg_rd_data;
    endtask

    task automatic preload(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] c;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(2'd3, c);
            if (c[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(i[1:0], v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 idle outputs", {29'd0, mem_valid, dev_ack, dev_tc}, 32'h0);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wr(2'd3, 32'hffff_ffff);
        rd(2'd3, v);
        chk("R2 control write mask", v, 32'hfd00_0e00);
        wr(2'd3, 32'h0040_0001);
        rd(2'd3, v);
        chk("R2 status bits not writable", v, 32'h0);
    endtask

    task automatic t_addr_regs();
        logic [31:0] v;
        wr(2'd1, 32'h1234_5677);
        rd(2'd1, v);
        chk("R3 virtual low bits cleared", v, 32'h1234_5674);
        wr(2'd0, 32'h0000_0103);
        rd(2'd0, v);
        chk("R3 real address stored", v, 32'h0000_0103);
    endtask

    task automatic t_dev_to_mem(input logic waits, input logic [5:0] base, input string tag);
        logic [31:0] v;
        int a0, t0;
        wait_mode = waits;
        wr(2'd0, {26'd0, base});
        wr(2'd1, 32'h0000_0020);
        wr(2'd2, 32'd3);
        wr(2'd3, 32'h0);
        a0 = ack_n; t0 = tc_n;
        dev_base = 8'hA0 - ack_n[7:0];
        @(negedge clk); dev_req = 1'b1;
        wait_done();
        dev_req = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk({tag, " R5 device-to-memory byte"}, {24'd0, mem[base + 6'(i)]}, 32'hA0 + i);
        rd(2'd0, v); chk({tag, " R6 real address advanced"}, v, {26'd0, base} + 32'd3);
        rd(2'd1, v); chk({tag, " R6 virtual address advanced"}, v, 32'h23);
        rd(2'd2, v); chk({tag, " R6 count decremented"}, v, 32'd0);
        rd(2'd3, v); chk({tag, " R7 done bit"}, v, 32'h1);
        chk({tag, " R7 single tc pulse"}, tc_n - t0, 32'd1);
        chk({tag, " R7 no extra bytes"}, ack_n - a0, 32'd3);
        wait_mode = 1'b0;
    endtask

    task automatic t_ungranted();
        logic [31:0] v;
        int m0;
        arb_ctl = 16'hFFFB;
        wr(2'd0, 32'h28);
        wr(2'd2, 32'd2);
        wr(2'd3, 32'h0);
        m0 = mv_n;
        @(negedge clk); dev_req = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd3, v); chk("R4 busy while ungranted", v, 32'h0200_0000);
        rd(2'd2, v); chk("R4 count held while ungranted", v, 32'd2);
        chk("R4 no memory access ungranted", mv_n - m0, 32'd0);
        arb_ctl = 16'h0004;
        wait_done();
        dev_req = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk("R4 busy cleared after grant", v, 32'h1);
    endtask

    task automatic t_req_low();
        logic [31:0] v;
        int m0;
        wr(2'd2, 32'd2);
        wr(2'd3, 32'h0);
        m0 = mv_n;
        repeat (8) @(negedge clk);
        rd(2'd2, v); chk("R6 no transfer without request", v, 32'd2);
        chk("R6 no memory access without request", mv_n - m0, 32'd0);
    endtask

    task automatic t_mem_to_dev(input logic forced_start, input string tag);
        logic [31:0] v;
        int a0;
        preload(6'h30, 8'h5A);
        preload(6'h31, 8'hC3);
        wr(2'd0, 32'h30);
        wr(2'd2, 32'd2);
        a0 = ack_n;
        if (forced_start) begin
            wr(2'd3, 32'h6000_0000);
        end else begin
            wr(2'd3, 32'h4000_0000);
            @(negedge clk); dev_req = 1'b1;
        end
        wait_done();
        dev_req = 1'b0;
        repeat (4) @(negedge clk);
        chk({tag, " first byte to device"}, {24'd0, cap[a0[7:0]]}, 32'h5A);
        chk({tag, " second byte to device"}, {24'd0, cap[8'(a0 + 1)]}, 32'hC3);
        chk({tag, " byte count"}, ack_n - a0, 32'd2);
        rd(2'd3, v);
        chk({tag, " control after done"}, v, forced_start ? 32'h6000_0001 : 32'h4000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_addr_regs();
        t_dev_to_mem(1'b0, 6'h10, "plain");
        t_ungranted();
        t_req_low();
        t_mem_to_dev(1'b0, "R5 memory-to-device");
        t_mem_to_dev(1'b1, "R8 forced start");
        t_dev_to_mem(1'b1, 6'h08, "R9 wait states");
        chk("R9 address stable during stall", stall_err, 32'd0);
        report();
        $finish;
    end
endmodule